// File: doc/BRIEF.md
# Cartridge Memory-Map Control Register

This block sits on the cartridge side of a handheld console's cartridge bus and decides which on-cart device answers each access. A small control register lives at one fixed address near the top of the 32 MiB ROM window and is loaded by an ordinary bus write to that address. Its bits choose whether the boot flash or the SDRAM answers in the ROM window. They also gate SDRAM reads, protect SDRAM from writes, and open an SD-card I/O window over the upper 16 MiB of the ROM window.

One register bit has two jobs. It enables SDRAM reads and it also drives the upper address line of the save SRAM, so both 64 KB halves of a 128 KB SRAM can be reached. The bus seen by the block is simplified: a 28-bit byte address, separate read and write strobes, and write data. The block answers with one-hot, active-high chip selects and the SRAM bank line. Device timing, the SD protocol and flash command sequences are handled elsewhere.

Top module: `cart_map_ctrl`

## Requirements
- R1: After reset the register holds zero. A ROM-window read then selects the flash, no SD window is open, and `sram_a16` is 0.
- R2: A write (`bus_wr`=1) to byte address 0x9FFFFFE loads `bus_wdata[3:0]` into the register at the next rising clock edge. A read of that address, or a write to any other address, leaves the register unchanged.
- R3: During a write cycle to 0x9FFFFFE no chip select is asserted.
- R4: Register bit 0 picks the ROM-window device: 0 means flash and 1 means SDRAM. When bit 0 is 1, a read selects the SDRAM only if bit 2 is 1; otherwise no device answers.
- R5: While register bit 1 is 1, every ROM-window access with address bit 24 set (0x9000000 to 0x9FFFFFF) asserts only `sd_cs`. Accesses with bit 24 clear are decoded as if bit 1 were 0.
- R6: While register bit 3 is 1, a write to SDRAM in the ROM window asserts no chip select. While bit 3 is 0, a write with bit 0 set selects the SDRAM whatever bit 2 holds. A write with bit 0 clear selects the flash.
- R7: `sram_a16` always equals register bit 2. Any access with address bits [27:24] equal to 0xE asserts `sram_cs`, whatever the register holds.
- R8: A read of 0x9FFFFFE is decoded like any other ROM-window address and does not return the register.
- R9: The ROM window is addresses with bits [27:25] equal to 3'b100. With no strobe active, or for addresses outside the ROM and SRAM windows, all chip selects are 0. At most one chip select is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 28 | Byte address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data; bits [3:0] load the register |
| flash_cs | output | 1 | Boot flash select |
| sdram_cs | output | 1 | SDRAM select |
| sd_cs | output | 1 | SD-card I/O port select |
| sram_cs | output | 1 | Save SRAM select |
| sram_a16 | output | 1 | Save SRAM bank address line |

## Verification
The chip selects are combinational from the address, the strobes and the present register value. They are therefore due in the same cycle as the access. The bench drives each access on a falling edge and samples the outputs one time unit later, before any rising edge can intervene. A register write takes effect at the rising edge that ends its cycle. The bench checks the write cycle itself (no selects, old bank line) in the write's own half-cycle, and checks the new decode only on accesses driven at later falling edges. All 16 register values are swept against low ROM, high ROM, the register address, the SRAM window and an unmapped address, with both reads and writes.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int ADDR_W = 28;
    localparam int DATA_W = 16;
    localparam int CTRL_W = 4;

    // Window decode: ROM window is a 32 MiB span, SRAM window a 16 MiB span.
    localparam int ROM_TAG_LSB  = 25;
    localparam int SRAM_TAG_LSB = 24;
    localparam logic [ADDR_W-1:ROM_TAG_LSB]  ROM_TAG  = 3'b100;
    localparam logic [ADDR_W-1:SRAM_TAG_LSB] SRAM_TAG = 4'hE;
    localparam int HALF_BIT = ROM_TAG_LSB - 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 28'h9FF_FFFE;

    // Bit order matters: field order gives bits 3..0.
    typedef struct packed {
        logic wprot;      // bit 3
        logic sdram_rd;   // bit 2, also SRAM bank line
        logic sd_win;     // bit 1
        logic map_sdram;  // bit 0
    } ctrl_t;

    typedef enum logic [1:0] {
        RGN_OTHER = 2'd0,
        RGN_ROM   = 2'd1,
        RGN_SRAM  = 2'd2
    } region_e;

    typedef struct packed {
        logic flash;
        logic sdram;
        logic sd;
        logic sram;
    } sel_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:ROM_TAG_LSB] == ROM_TAG)
            return RGN_ROM;
        else if (a[ADDR_W-1:SRAM_TAG_LSB] == SRAM_TAG)
            return RGN_SRAM;
        else
            return RGN_OTHER;
    endfunction

endpackage

// File: rtl/cmc_addr_decode.sv
module cmc_addr_decode
    import cart_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              upper_half,
    output logic              is_ctrl
);
    always_comb begin
        region     = region_of(addr);
        upper_half = addr[HALF_BIT];
        is_ctrl    = (addr == CTRL_ADDR);
    end
endmodule

// File: rtl/cmc_ctrl_reg.sv
module cmc_ctrl_reg
    import cart_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              is_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr && is_ctrl)
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
endmodule

// File: rtl/cmc_select.sv
module cmc_select
    import cart_map_pkg::*;
(
    input  ctrl_t   ctrl,
    input  region_e region,
    input  logic    upper_half,
    input  logic    is_ctrl,
    input  logic    rd,
    input  logic    wr,
    output sel_t    sel
);
    logic active;

    always_comb begin
        active = (rd || wr) && !(wr && is_ctrl);
        sel    = '0;
        if (active) begin
            unique case (region)
                RGN_SRAM: sel.sram = 1'b1;
                RGN_ROM: begin
                    if (ctrl.sd_win && upper_half)
                        sel.sd = 1'b1;
                    else if (!ctrl.map_sdram)
                        sel.flash = 1'b1;
                    else if (wr)
                        sel.sdram = !ctrl.wprot;
                    else
                        sel.sdram = ctrl.sdram_rd;
                end
                default: sel = '0;
            endcase
        end
    end
endmodule

// File: rtl/cart_map_ctrl.sv
module cart_map_ctrl
    import cart_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              flash_cs,
    output logic              sdram_cs,
    output logic              sd_cs,
    output logic              sram_cs,
    output logic              sram_a16
);
    region_e region;
    logic    upper_half;
    logic    is_ctrl;
    ctrl_t   ctrl_q;
    sel_t    sel;

    cmc_addr_decode u_dec (
        .addr       (bus_addr),
        .region     (region),
        .upper_half (upper_half),
        .is_ctrl    (is_ctrl)
    );

    cmc_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .is_ctrl (is_ctrl),
        .wdata   (bus_wdata),
        .ctrl    (ctrl_q)
    );

    cmc_select u_sel (
        .ctrl       (ctrl_q),
        .region     (region),
        .upper_half (upper_half),
        .is_ctrl    (is_ctrl),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .sel        (sel)
    );

    assign flash_cs = sel.flash;
    assign sdram_cs = sel.sdram;
    assign sd_cs    = sel.sd;
    assign sram_cs  = sel.sram;
    assign sram_a16 = ctrl_q.sdram_rd;
endmodule

// File: rtl/cart_map_ctrl_chk.sv
module cart_map_ctrl_chk
    import cart_map_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              flash_cs,
    input logic              sdram_cs,
    input logic              sd_cs,
    input logic              sram_cs,
    input logic              sram_a16,
    input logic [CTRL_W-1:0] ctrl_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0));

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == CTRL_ADDR) |=> $stable(ctrl_q));

    // R3
    ctrl_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CTRL_ADDR) |-> !(flash_cs || sdram_cs || sd_cs || sram_cs));

    // R4
    flash_map_chk: assert property (@(posedge clk) disable iff (rst)
        flash_cs |-> !ctrl_q[0]);

    // R4
    sdram_read_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (sdram_cs && bus_rd) |-> (ctrl_q[0] && ctrl_q[2]));

    // R5
    sd_window_chk: assert property (@(posedge clk) disable iff (rst)
        sd_cs |-> (ctrl_q[1] && bus_addr[HALF_BIT] && bus_addr[ADDR_W-1:ROM_TAG_LSB] == ROM_TAG));

    // R6
    write_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (sdram_cs && bus_wr) |-> !ctrl_q[3]);

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_cs, sdram_cs, sd_cs, sram_cs}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |-> !(flash_cs || sdram_cs || sd_cs || sram_cs));
endmodule

bind cart_map_ctrl cart_map_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .flash_cs (flash_cs),
    .sdram_cs (sdram_cs),
    .sd_cs    (sd_cs),
    .sram_cs  (sram_cs),
    .sram_a16 (sram_a16),
    .ctrl_q   (ctrl_q)
);

// File: tb/cart_map_ctrl_tb_top.sv
module cart_map_ctrl_tb_top;
    localparam logic [27:0] REG_A  = 28'h9FF_FFFE;
    localparam logic [27:0] LOW_A  = 28'h800_0100;
    localparam logic [27:0] HIGH_A = 28'h900_0200;
    localparam logic [27:0] SRAM_A = 28'hE00_1234;
    localparam logic [27:0] OFF_A  = 28'h300_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        flash_cs, sdram_cs, sd_cs, sram_cs, sram_a16;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cart_map_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .flash_cs  (flash_cs),
        .sdram_cs  (sdram_cs),
        .sd_cs     (sd_cs),
        .sram_cs   (sram_cs),
        .sram_a16  (sram_a16)
    );

    // Expected {flash, sdram, sd, sram, a16} from the requirements.
    function automatic logic [4:0] model(input logic [3:0] c, input logic [27:0] a,
                                         input logic rd, input logic wr);
        logic f, s, d, m;
        f = 0; s = 0; d = 0; m = 0;
        if ((rd || wr) && !(wr && a == REG_A)) begin
            if (a[27:24] == 4'hE) m = 1;
            else if (a[27:25] == 3'b100) begin
                if (c[1] && a[24]) d = 1;
                else if (!c[0]) f = 1;
                else if (wr) s = !c[3];
                else s = c[2];
            end
        end
        return {f, s, d, m, c[2]};
    endfunction

    task automatic compare(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {flash_cs, sdram_cs, sd_cs, sram_cs, sram_a16};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h rd=%0b wr=%0b act=%b exp=%b",
                     req, bus_addr, bus_rd, bus_wr, act, exp);
        end
    endtask

    task automatic access(input string req, input logic [3:0] c, input logic [27:0] a,
                          input logic rd, input logic wr);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = 16'hFFFF;
        #1 compare(req, model(c, a, rd, wr));
    endtask

    // Writes the register; checks the write cycle itself (R3, old bank line).
    task automatic load_ctrl(input logic [3:0] old_c, input logic [3:0] v);
        @(negedge clk);
        bus_addr = REG_A; bus_rd = 0; bus_wr = 1; bus_wdata = {12'hABC, v};
        #1 compare("R3", {4'b0000, old_c[2]});
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; bus_addr = OFF_A;
        #1 compare("R7", {4'b0000, v[2]});
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        access("R1", 4'h0, LOW_A, 1, 0);
        access("R1", 4'h0, HIGH_A, 1, 0);
        // R9: idle and unmapped
        access("R9", 4'h0, LOW_A, 0, 0);
        // R2: write to a neighbour address and a read of the register leave it at zero
        access("R2", 4'h0, REG_A - 28'd2, 0, 1);
        access("R2", 4'h0, LOW_A, 1, 0);
        access("R8", 4'h0, REG_A, 1, 0);
        access("R2", 4'h0, HIGH_A, 1, 0);

        // Sweep every register value against every address class.
        for (int v = 0; v < 16; v++) begin
            logic [3:0] prev;
            prev = (v == 0) ? 4'h0 : 4'(v - 1);
            load_ctrl(prev, 4'(v));
            access("R4", 4'(v), LOW_A, 1, 0);
            access("R6", 4'(v), LOW_A, 0, 1);
            access("R5", 4'(v), HIGH_A, 1, 0);
            access("R5", 4'(v), HIGH_A, 0, 1);
            access("R8", 4'(v), REG_A, 1, 0);
            access("R7", 4'(v), SRAM_A, 1, 0);
            access("R7", 4'(v), SRAM_A, 0, 1);
            access("R9", 4'(v), OFF_A, 1, 0);
            access("R9", 4'(v), OFF_A, 0, 1);
            access("R9", 4'(v), HIGH_A, 0, 0);
        end

        // R1: reset again from 0xF returns to the cleared map
        @(negedge clk); rst = 1; bus_rd = 0; bus_wr = 0;
        @(negedge clk); rst = 0;
        access("R1", 4'h0, HIGH_A, 1, 0);
        access("R1", 4'h0, SRAM_A, 1, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule